// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervision counter that must be serviced by software before it runs out. It advances once for every pulse on a slow tick-enable input, nominally one pulse per millisecond. When the count reaches a limit chosen by a 4-bit period select, the block raises a timeout event. The limit is a power of two plus one tick, and ranges from 9 to 262145 ticks.

A 3-bit window select can add a lower closed window, set in eighths of the period. A service strobe that arrives while the count is still inside that window is a fault. The block treats such a fault exactly like a timeout.

A timeout event has one of two results, chosen by a reset-disable control. With the control clear, the event drives a one-clock reset pulse. With it set, the event sets a sticky interrupt flag, which software clears by writing a one. The counter can be frozen while the system sleeps or while a debugger halts it. The period, window and reset-disable fields are locked while the watchdog runs.

Top module: `winwdg`

## Requirements
- R1: After reset, `wdt_rst_o` and `irq_o` are low, the watchdog is disabled, the flag is clear, and every configuration field reads as zero.
- R2: While enabled and allowed to run, the counter rises by one on each clock where `tick_en` is high. With period select `s`, the limit is L = 2^(3+s)+1. The clock edge after the counter equals L raises an expiry event and returns the counter to zero. The outputs show the event one clock later.
- R3: A `feed` strobe while enabled, if not a fault under R4, returns the counter to zero on the next clock and raises no event.
- R4: Window select 0 turns the window off. A value n from 1 to 7 sets a boundary of n·2^s ticks. A feed while the count is below the boundary raises an event that is handled like an expiry.
- R5: With reset-disable clear, each event makes `wdt_rst_o` high for exactly the one clock that follows the event cycle.
- R6: With reset-disable set, an event never drives `wdt_rst_o`. It sets the interrupt flag, and the counter restarts from zero and keeps running.
- R7: The flag is sticky. A clock with `flag_clr` high clears it, and a new event in that same clock wins over the clear.
- R8: `irq_o` is the flag ANDed with the interrupt-enable field, and both are registered.
- R9: With run-in-sleep clear, the counter holds while `sleep_i` is high. With run-in-debug clear, it holds while `debug_halt_i` is high.
- R10: While the watchdog is disabled, the counter stays at zero, `feed` is ignored and no event occurs. Enabling it starts the count from zero.
- R11: A `cfg_we` write updates period select, window select and reset-disable only while the watchdog is disabled. Enable, interrupt-enable, run-in-sleep and run-in-debug are written at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-clock tick that advances the counter |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable value to write |
| cfg_period_sel | input | SEL_W | Period select value to write |
| cfg_window_sel | input | WIN_W | Window select value to write |
| cfg_rst_disable | input | 1 | Reset-disable value to write |
| cfg_irq_enable | input | 1 | Interrupt-enable value to write |
| cfg_run_sleep | input | 1 | Keep counting while asleep when set |
| cfg_run_debug | input | 1 | Keep counting while debug-halted when set |
| feed | input | 1 | One-clock service strobe |
| sleep_i | input | 1 | System sleep status |
| debug_halt_i | input | 1 | Debugger halt status |
| flag_clr | input | 1 | Write-one-to-clear for the interrupt flag |
| wdt_rst_o | output | 1 | Registered reset pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
An input applied before clock edge k affects the counter at edge k. An expiry needs one more edge to be detected, since it is raised in the cycle after the count equals L. Its pulse or flag then appears after edge k+1, and a configuration write takes effect at the edge that samples it. The bench holds a behavioural reference that follows the same edge accounting. It drives stimulus on falling edges and compares both outputs on every falling edge, half a period after the registers have settled. Directed counts of reset pulses over fixed windows cover the whole span of each pulse, so no sample falls on a transition.

// File: rtl/winwdg_pkg.sv
package winwdg_pkg;

  typedef struct packed {
    logic enable;
    logic irq_en;
    logic run_sleep;
    logic run_dbg;
  } ctrl_t;

  typedef enum logic [1:0] {
    EV_NONE   = 2'd0,
    EV_EXPIRE = 2'd1,
    EV_EARLY  = 2'd2
  } ev_e;

  function automatic logic run_allowed(ctrl_t c, logic sleeping, logic halted);
    return (c.run_sleep | ~sleeping) & (c.run_dbg | ~halted);
  endfunction

endpackage

// File: rtl/winwdg_cfg.sv
module winwdg_cfg
  import winwdg_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int WIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  ctrl_t            wr_ctrl_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [WIN_W-1:0] wr_win_i,
  input  logic             wr_rdis_i,
  output ctrl_t            ctrl_o,
  output logic [SEL_W-1:0] sel_o,
  output logic [WIN_W-1:0] win_o,
  output logic             rdis_o
);

  ctrl_t            ctrl_q, ctrl_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic             rdis_q, rdis_d;
  logic             lock_open;
  logic             lock_wr;

  assign lock_open = ~ctrl_q.enable;
  assign lock_wr   = we_i & lock_open;

  always_comb begin
    ctrl_d = ctrl_q;
    sel_d  = sel_q;
    win_d  = win_q;
    rdis_d = rdis_q;
    if (we_i) begin
      ctrl_d = wr_ctrl_i;
    end
    if (lock_wr) begin
      sel_d  = wr_sel_i;
      win_d  = wr_win_i;
      rdis_d = wr_rdis_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      win_q  <= '0;
      rdis_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      sel_q  <= sel_d;
      win_q  <= win_d;
      rdis_q <= rdis_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign sel_o  = sel_q;
  assign win_o  = win_q;
  assign rdis_o = rdis_q;

endmodule

// File: rtl/winwdg_limits.sv
module winwdg_limits #(
  parameter int SEL_W      = 4,
  parameter int WIN_W      = 3,
  parameter int BASE_SHIFT = 3,
  parameter int CNT_W      = 19,
  parameter bit WINDOW_EN  = 1'b1
) (
  input  logic [SEL_W-1:0] sel_i,
  input  logic [WIN_W-1:0] win_i,
  output logic [CNT_W-1:0] limit_o,
  output logic [CNT_W-1:0] bound_o,
  output logic             win_on_o
);

  localparam int UNIT_SH = BASE_SHIFT - WIN_W;

  assign limit_o = (CNT_W'(1) << (CNT_W'(sel_i) + CNT_W'(BASE_SHIFT))) + CNT_W'(1);

  generate
    if (WINDOW_EN) begin : g_window
      assign bound_o  = CNT_W'(win_i) << (CNT_W'(sel_i) + CNT_W'(UNIT_SH));
      assign win_on_o = |win_i;
    end else begin : g_no_window
      assign bound_o  = '0;
      assign win_on_o = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/winwdg_count.sv
module winwdg_count
  import winwdg_pkg::*;
#(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             run_ok_i,
  input  logic             feed_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic [CNT_W-1:0] bound_i,
  input  logic             win_on_i,
  output logic [CNT_W-1:0] cnt_o,
  output ev_e              ev_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;
  logic             early;
  logic             step;

  assign hit   = en_i & (cnt_q == limit_i);
  assign early = en_i & feed_i & win_on_i & (cnt_q < bound_i);
  assign step  = tick_i & run_ok_i;

  always_comb begin
    if (hit)        ev_o = EV_EXPIRE;
    else if (early) ev_o = EV_EARLY;
    else            ev_o = EV_NONE;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)                      cnt_d = '0;
    else if (feed_i | hit | early)  cnt_d = '0;
    else if (step)                  cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/winwdg_event.sv
module winwdg_event
  import winwdg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ev_e  ev_i,
  input  logic rdis_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic rst_pulse_o,
  output logic flag_o,
  output logic irq_o
);

  logic fire;
  logic pulse_q, pulse_d;
  logic flag_q, flag_d;

  assign fire = (ev_i != EV_NONE);

  always_comb begin
    pulse_d = fire & ~rdis_i;
    flag_d  = (fire & rdis_i) | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      flag_q  <= flag_d;
    end
  end

  assign rst_pulse_o = pulse_q;
  assign flag_o      = flag_q;
  assign irq_o       = flag_q & irq_en_i;

endmodule

// File: rtl/winwdg.sv
module winwdg
  import winwdg_pkg::*;
#(
  parameter int SEL_W      = 4,
  parameter int WIN_W      = 3,
  parameter int BASE_SHIFT = 3,
  parameter bit WINDOW_EN  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             cfg_we,
  input  logic             cfg_enable,
  input  logic [SEL_W-1:0] cfg_period_sel,
  input  logic [WIN_W-1:0] cfg_window_sel,
  input  logic             cfg_rst_disable,
  input  logic             cfg_irq_enable,
  input  logic             cfg_run_sleep,
  input  logic             cfg_run_debug,
  input  logic             feed,
  input  logic             sleep_i,
  input  logic             debug_halt_i,
  input  logic             flag_clr,
  output logic             wdt_rst_o,
  output logic             irq_o
);

  localparam int CNT_W = BASE_SHIFT + (1 << SEL_W);

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  ctrl_t            wr_ctrl;
  ctrl_t            ctrl_q;
  logic [SEL_W-1:0] sel_q;
  logic [WIN_W-1:0] win_q;
  logic             rdis_q;
  logic             en_q;
  logic             run_ok;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] bound;
  logic             win_on;
  logic [CNT_W-1:0] cnt_q;
  ev_e              ev;
  logic             flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign wr_ctrl.enable    = cfg_enable;
  assign wr_ctrl.irq_en    = cfg_irq_enable;
  assign wr_ctrl.run_sleep = cfg_run_sleep;
  assign wr_ctrl.run_dbg   = cfg_run_debug;

  winwdg_cfg #(.SEL_W(SEL_W), .WIN_W(WIN_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .we_i      (cfg_we),
    .wr_ctrl_i (wr_ctrl),
    .wr_sel_i  (cfg_period_sel),
    .wr_win_i  (cfg_window_sel),
    .wr_rdis_i (cfg_rst_disable),
    .ctrl_o    (ctrl_q),
    .sel_o     (sel_q),
    .win_o     (win_q),
    .rdis_o    (rdis_q)
  );

  assign en_q   = ctrl_q.enable;
  assign run_ok = run_allowed(ctrl_q, sleep_i, debug_halt_i);

  winwdg_limits #(
    .SEL_W(SEL_W), .WIN_W(WIN_W), .BASE_SHIFT(BASE_SHIFT),
    .CNT_W(CNT_W), .WINDOW_EN(WINDOW_EN)
  ) u_limits (
    .sel_i    (sel_q),
    .win_i    (win_q),
    .limit_o  (limit),
    .bound_o  (bound),
    .win_on_o (win_on)
  );

  winwdg_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .en_i     (en_q),
    .tick_i   (tick_en),
    .run_ok_i (run_ok),
    .feed_i   (feed),
    .limit_i  (limit),
    .bound_i  (bound),
    .win_on_i (win_on),
    .cnt_o    (cnt_q),
    .ev_o     (ev)
  );

  winwdg_event u_event (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ev_i        (ev),
    .rdis_i      (rdis_q),
    .irq_en_i    (ctrl_q.irq_en),
    .clr_i       (flag_clr),
    .rst_pulse_o (wdt_rst_o),
    .flag_o      (flag_q),
    .irq_o       (irq_o)
  );

endmodule

// File: rtl/winwdg_checker.sv
module winwdg_checker #(
  parameter int SEL_W = 4,
  parameter int WIN_W = 3,
  parameter int CNT_W = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [SEL_W-1:0] sel,
  input logic [WIN_W-1:0] win,
  input logic             rdis,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit,
  input logic             feed,
  input logic             run_ok,
  input logic             cfg_we,
  input logic             flag,
  input logic             flag_clr,
  input logic             wdt_rst
);

  assert_cnt_within_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

  assert_feed_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && feed && !cfg_we) |=> (cnt == '0));

  assert_no_reset_in_irq_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> $past(!rdis));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  assert_pause_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !run_ok && !feed && !cfg_we && (cnt != limit)) |=> $stable(cnt));

  assert_idle_no_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wdt_rst);

  assert_fields_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ($stable(sel) && $stable(win) && $stable(rdis)));

endmodule

bind winwdg winwdg_checker #(.SEL_W(SEL_W), .WIN_W(WIN_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .en       (en_q),
  .sel      (sel_q),
  .win      (win_q),
  .rdis     (rdis_q),
  .cnt      (cnt_q),
  .limit    (limit),
  .feed     (feed),
  .run_ok   (run_ok),
  .cfg_we   (cfg_we),
  .flag     (flag_q),
  .flag_clr (flag_clr),
  .wdt_rst  (wdt_rst_o)
);

// File: tb/sim_winwdg.sv
module sim_winwdg;

  localparam int CLK_PERIOD = 10;
  localparam int SEL_W = 4;
  localparam int WIN_W = 3;
  localparam int WATCHDOG_CYCLES = 20000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick_en = 1'b0;
  logic             cfg_we = 1'b0;
  logic             cfg_enable = 1'b0;
  logic [SEL_W-1:0] cfg_period_sel = '0;
  logic [WIN_W-1:0] cfg_window_sel = '0;
  logic             cfg_rst_disable = 1'b0;
  logic             cfg_irq_enable = 1'b0;
  logic             cfg_run_sleep = 1'b0;
  logic             cfg_run_debug = 1'b0;
  logic             feed = 1'b0;
  logic             sleep_i = 1'b0;
  logic             debug_halt_i = 1'b0;
  logic             flag_clr = 1'b0;
  logic             wdt_rst_o;
  logic             irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  int tick_div = 1;
  int tick_phase = 0;
  int rst_seen = 0;
  bit running = 1'b0;
  string cur_req = "R1";

  // reference state
  int m_en, m_sel, m_win, m_rdis, m_ie, m_rs, m_rd;
  int m_cnt, m_flag, m_rst;

  winwdg u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cfg_we(cfg_we),
    .cfg_enable(cfg_enable), .cfg_period_sel(cfg_period_sel),
    .cfg_window_sel(cfg_window_sel), .cfg_rst_disable(cfg_rst_disable),
    .cfg_irq_enable(cfg_irq_enable), .cfg_run_sleep(cfg_run_sleep),
    .cfg_run_debug(cfg_run_debug), .feed(feed), .sleep_i(sleep_i),
    .debug_halt_i(debug_halt_i), .flag_clr(flag_clr),
    .wdt_rst_o(wdt_rst_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sel = 0; m_win = 0; m_rdis = 0; m_ie = 0; m_rs = 0; m_rd = 0;
      m_cnt = 0; m_flag = 0; m_rst = 0;
    end else begin
      int lim, bnd, ev, go;
      lim = (8 << m_sel) + 1;
      bnd = m_win * (lim / 8);
      ev = 0;
      if (m_en != 0) begin
        if (m_cnt == lim) ev = 1;
        if (feed && m_win != 0 && m_cnt < bnd) ev = 1;
      end
      go = (m_rs != 0 || !sleep_i) && (m_rd != 0 || !debug_halt_i);
      if (m_en == 0) m_cnt = 0;
      else if (feed || ev != 0) m_cnt = 0;
      else if (tick_en && go) m_cnt = m_cnt + 1;
      if (ev != 0 && m_rdis != 0) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_rst = (ev != 0 && m_rdis == 0) ? 1 : 0;
      if (cfg_we) begin
        if (m_en == 0) begin
          m_sel = int'(cfg_period_sel); m_win = int'(cfg_window_sel); m_rdis = int'(cfg_rst_disable);
        end
        m_en = int'(cfg_enable); m_ie = int'(cfg_irq_enable);
        m_rs = int'(cfg_run_sleep); m_rd = int'(cfg_run_debug);
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (running) begin
      chk({cur_req, " reset output"}, int'(wdt_rst_o), m_rst);
      chk({cur_req, " irq output"}, int'(irq_o), (m_flag != 0 && m_ie != 0) ? 1 : 0);
      if (wdt_rst_o) rst_seen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      feed = 1'b0;
      cfg_we = 1'b0;
      flag_clr = 1'b0;
      tick_en = (tick_div <= 1) ? 1'b1 : ((tick_phase % tick_div) == 0);
      tick_phase++;
    end
  endtask

  task automatic wr_cfg(input bit en, input int sel, input int win, input bit rdis,
                        input bit ie, input bit rs, input bit rd);
    cfg_enable = en;
    cfg_period_sel = SEL_W'(sel);
    cfg_window_sel = WIN_W'(win);
    cfg_rst_disable = rdis;
    cfg_irq_enable = ie;
    cfg_run_sleep = rs;
    cfg_run_debug = rd;
    cfg_we = 1'b1;
    cyc(1);
  endtask

  task automatic pulses_in(input string req, input int n, input int exp);
    int base;
    base = rst_seen;
    cyc(n);
    chk({req, " pulse count"}, rst_seen - base, exp);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    running = 1'b1;
    cyc(4);
    // R1: reset state
    chk("R1 reset idle", int'(wdt_rst_o), 0);
    chk("R1 irq idle", int'(irq_o), 0);

    // R2 R5: shortest period, no feeds; pulses after edges E+10 and E+20
    cur_req = "R2/R5";
    wr_cfg(1, 0, 0, 0, 0, 1, 1);
    pulses_in("R2 R5 period 9", 24, 2);

    // R11: locked fields ignored while running
    cur_req = "R11";
    wr_cfg(1, 15, 7, 1, 0, 1, 1);
    pulses_in("R11 lock keeps period", 30, 3);

    // R3: regular legal feeds keep it quiet
    cur_req = "R3";
    for (int k = 0; k < 8; k++) begin
      cyc(5);
      feed = 1'b1;
    end
    cyc(1);
    pulses_in("R3 fed", 4, 0);

    // R10: disabled, feeds ignored, no events
    cur_req = "R10";
    wr_cfg(0, 0, 0, 0, 0, 1, 1);
    feed = 1'b1;
    pulses_in("R10 disabled", 30, 0);

    // R6 R8: reset-disabled mode, period 17
    cur_req = "R6/R8";
    wr_cfg(1, 1, 0, 1, 1, 1, 1);
    pulses_in("R6 no reset", 22, 0);
    chk("R6 R8 irq after expiry", int'(irq_o), 1);

    // R7: sticky, cleared by write one, set wins over clear
    cur_req = "R7";
    cyc(5);
    chk("R7 sticky", int'(irq_o), 1);
    flag_clr = 1'b1;
    cyc(2);
    chk("R7 cleared", int'(irq_o), 0);
    for (int k = 0; k < 20; k++) begin
      flag_clr = 1'b1;
      cyc(1);
    end
    // R8: mask with interrupt enable
    cur_req = "R8";
    wr_cfg(1, 1, 0, 1, 0, 1, 1);
    cyc(20);
    chk("R8 masked", int'(irq_o), 0);
    wr_cfg(1, 1, 0, 1, 1, 1, 1);
    cyc(1);
    chk("R8 unmasked", int'(irq_o), 1);

    // R4: window 3 of period 17 gives boundary 6
    cur_req = "R4";
    wr_cfg(0, 0, 0, 0, 1, 1, 1);
    flag_clr = 1'b1;
    cyc(1);
    wr_cfg(1, 1, 3, 0, 1, 1, 1);
    cyc(3);
    feed = 1'b1;
    pulses_in("R4 early feed faults", 4, 1);
    cyc(6);
    feed = 1'b1;
    pulses_in("R4 late feed legal", 6, 0);
    wr_cfg(0, 0, 0, 0, 1, 1, 1);
    wr_cfg(1, 1, 7, 1, 1, 1, 1);
    feed = 1'b1;
    cyc(2);
    chk("R4 early feed sets flag", int'(irq_o), 1);

    // R9: pause on sleep and on debug halt
    cur_req = "R9";
    wr_cfg(0, 0, 0, 0, 0, 0, 0);
    flag_clr = 1'b1;
    cyc(1);
    sleep_i = 1'b1;
    wr_cfg(1, 0, 0, 0, 0, 0, 0);
    pulses_in("R9 sleep holds", 30, 0);
    sleep_i = 1'b0;
    debug_halt_i = 1'b1;
    pulses_in("R9 halt holds", 30, 0);
    wr_cfg(1, 0, 0, 0, 0, 0, 1);
    pulses_in("R9 run in debug", 12, 1);
    debug_halt_i = 1'b0;

    // R2: sparse ticks, one every third clock
    cur_req = "R2";
    wr_cfg(0, 0, 0, 0, 0, 1, 1);
    tick_div = 3;
    wr_cfg(1, 0, 0, 0, 0, 1, 1);
    pulses_in("R2 sparse ticks", 60, 2);
    tick_div = 1;

    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule